// File: doc/BRIEF.md
# Dual H-Bridge Drive Command Decoder

This block sits between the logic pins of a two-channel brushed-DC motor driver and its chopper or gate-driver stage. Each bridge has three level inputs: two direction bits and a PWM gate. The block turns them into one 2-bit drive command per bridge: off (high impedance), short brake, forward or reverse. All inputs, including the two protection flags, pass through a synchronizer before they are decoded. The outputs are registered, so a pin change shows at the outputs a fixed number of clock edges later.

The block also has a global guard. When all six motor-control inputs are low, the device goes to standby and every bridge is forced off. When the over-temperature or over-current flag is raised, every bridge is forced off and a shutdown is latched. The latch outlives the flag. The only logic path that clears it is the all-low pattern, and reset also clears it. A pairing mode is captured during reset. In that mode, both bridges act on channel A's inputs so that they can drive one large motor in parallel. Each bridge also gives a one-cycle pulse when its direction bits change, which the downstream blanking logic can use.

Top module: `hbd_dual_bridge_ctrl`

## Requirements
- R1: While reset is held, both command outputs are 00, both change pulses and `fault_o` are 0, and `standby_o` and `all_off_o` are 1.
- R2: With direction bits 0/0 and PWM high, a bridge's command is off (00).
- R3: With PWM high, direction bits IN1=1/IN2=0 give forward (10) and IN1=0/IN2=1 give reverse (11).
- R4: With both direction bits high, a bridge's command is brake (01) at either PWM level.
- R5: With PWM low and exactly one direction bit high, a bridge's command is brake (01).
- R6: When all six motor inputs are low, `standby_o` and `all_off_o` are 1 and both commands are 00. If any one of those inputs is high, `standby_o` is 0.
- R7: In paired mode, bridge B's command and change pulse follow channel A's inputs, and bridge B's own inputs have no effect.
- R8: The pairing pin is sampled only while reset is held. Changing it during operation has no effect on the commands.
- R9: A high over-temperature or over-current flag sets `fault_o` and `all_off_o` and forces both commands to 00. This holds even while all six inputs are low and the flag is still high.
- R10: Once the flag has dropped, the fault stays latched under any input pattern that is not all-low. It clears when all six inputs are low.
- R11: A bridge's change pulse is high for exactly one cycle after its direction bits change. A change of PWM alone gives no pulse.
- R12: Outputs respond exactly SYNC_STAGES+1 rising edges after an input change. At the edge before that, they still show the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_mode_i | input | 1 | Bridge pairing request, captured during reset |
| a_in1_i | input | 1 | Bridge A direction bit 1 |
| a_in2_i | input | 1 | Bridge A direction bit 2 |
| a_pwm_i | input | 1 | Bridge A PWM gate |
| b_in1_i | input | 1 | Bridge B direction bit 1 |
| b_in2_i | input | 1 | Bridge B direction bit 2 |
| b_pwm_i | input | 1 | Bridge B PWM gate |
| over_temp_i | input | 1 | Over-temperature flag, active high |
| over_curr_i | input | 1 | Over-current flag, active high |
| a_cmd_o | output | 2 | Bridge A command (00 off, 01 brake, 10 forward, 11 reverse) |
| b_cmd_o | output | 2 | Bridge B command, same coding |
| a_chg_o | output | 1 | One-cycle pulse on a bridge A direction change |
| b_chg_o | output | 1 | One-cycle pulse on a bridge B direction change |
| all_off_o | output | 1 | Global off override (standby or fault) |
| standby_o | output | 1 | All six motor inputs are low |
| fault_o | output | 1 | Latched protective shutdown |

## Verification
The two bridges are given different patterns at the same time. This shows that each bridge decodes its own pins, and also catches a swap of forward and reverse. Patterns that change only PWM separate a brake decode from off, and also show that PWM does not cause a change pulse. Two cases separate standby from plain off: an all-low pattern, and a pattern where one lone PWM pin is high. A sequence of fault, flag release, a partial-low pattern and then a full all-low pattern shows that the latch clears only through the all-low path. Running in both pairing modes, and toggling the pairing pin afterwards, shows that the mode is fixed at reset.

// File: rtl/hbd_pkg.sv
// Shared types for the dual H-bridge command decoder.
// Assumes: two-bit command coding is consumed as-is by the driver stage.
package hbd_pkg;

    typedef enum logic [1:0] {
        CMD_OFF   = 2'b00,
        CMD_BRAKE = 2'b01,
        CMD_FWD   = 2'b10,
        CMD_REV   = 2'b11
    } drv_cmd_e;

    typedef struct packed {
        logic in1;
        logic in2;
        logic pwm;
    } br_in_t;

    // Map one bridge's pin levels to its drive command.
    function automatic drv_cmd_e decode_cmd(input br_in_t v);
        drv_cmd_e c;
        if (v.in1 && v.in2)        c = CMD_BRAKE;
        else if (!v.in1 && !v.in2) c = CMD_OFF;
        else if (!v.pwm)           c = CMD_BRAKE;
        else if (v.in1)            c = CMD_FWD;
        else                       c = CMD_REV;
        return c;
    endfunction

endpackage

// File: rtl/hbd_sync.sv
// Multi-flop level synchronizer for asynchronous pin inputs.
// Assumes: each bit is an independent slow level; no bus coherency needed.
module hbd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hbd_guard.sv
// Global standby detector and latched protective shutdown.
// Assumes: inputs are already synchronized; a flag present at the same
// time as the all-low pattern keeps the fault set.
module hbd_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic all_low_i,
    input  logic ot_i,
    input  logic oc_i,
    output logic force_off_o,
    output logic fault_o,
    output logic standby_o,
    output logic all_off_o
);

    logic fault_q;
    logic fault_nx;

    // Next latch state: any flag sets, only all-low clears.
    always_comb begin
        fault_nx    = ot_i | oc_i | (fault_q & ~all_low_i);
        force_off_o = fault_nx | all_low_i;
    end

    // Register the latch and the status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q   <= 1'b0;
            standby_o <= 1'b1;
            all_off_o <= 1'b1;
        end else begin
            fault_q   <= fault_nx;
            standby_o <= all_low_i;
            all_off_o <= force_off_o;
        end
    end

    assign fault_o = fault_q;

    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_i || oc_i) |=> fault_q); // R9
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !all_low_i) |=> fault_q); // R10
    AST_FAULT_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(all_low_i)); // R10

endmodule

// File: rtl/hbd_bridge.sv
// One bridge's command register and direction-change pulse.
// Assumes: in_i is synchronized; force_off_i is the global override.
module hbd_bridge
    import hbd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  br_in_t   in_i,
    input  logic     force_off_i,
    output drv_cmd_e cmd_o,
    output logic     chg_o
);

    logic [1:0] dir_prev;

    // Decode the pins, apply the override and detect direction changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o    <= CMD_OFF;
            chg_o    <= 1'b0;
            dir_prev <= 2'b00;
        end else begin
            cmd_o    <= force_off_i ? CMD_OFF : decode_cmd(in_i);
            chg_o    <= ({in_i.in1, in_i.in2} != dir_prev);
            dir_prev <= {in_i.in1, in_i.in2};
        end
    end

    AST_BOTH_HIGH_BRAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i.in1 && in_i.in2 && !force_off_i) |=> (cmd_o == CMD_BRAKE)); // R4
    AST_NO_PULSE_STEADY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ({in_i.in1, in_i.in2} == dir_prev) |=> !chg_o); // R11

endmodule

// File: rtl/hbd_dual_bridge_ctrl.sv
// Top: synchronizes pins, routes inputs per pairing mode and drives two
// bridge command registers under the global standby/fault override.
// Assumes: pair_mode_i is strapped; it is captured only during reset.
module hbd_dual_bridge_ctrl
    import hbd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pair_mode_i,
    input  logic       a_in1_i,
    input  logic       a_in2_i,
    input  logic       a_pwm_i,
    input  logic       b_in1_i,
    input  logic       b_in2_i,
    input  logic       b_pwm_i,
    input  logic       over_temp_i,
    input  logic       over_curr_i,
    output logic [1:0] a_cmd_o,
    output logic [1:0] b_cmd_o,
    output logic       a_chg_o,
    output logic       b_chg_o,
    output logic       all_off_o,
    output logic       standby_o,
    output logic       fault_o
);

    localparam int NUM_BR = 2;
    localparam int SYNC_W = 3 * NUM_BR + 2;

    logic [SYNC_W-1:0] raw;
    logic [SYNC_W-1:0] syn;
    logic              paired_q;
    logic              all_low;
    logic              force_off;
    br_in_t            chan_in [NUM_BR];
    drv_cmd_e          cmd     [NUM_BR];
    logic [NUM_BR-1:0] chg;

    assign raw = {over_curr_i, over_temp_i,
                  b_pwm_i, b_in2_i, b_in1_i,
                  a_pwm_i, a_in2_i, a_in1_i};

    hbd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    // Capture the pairing strap while reset is held; freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) paired_q <= pair_mode_i;
    end

    assign all_low = (syn[3*NUM_BR-1:0] == '0);

    hbd_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_low_i   (all_low),
        .ot_i        (syn[3*NUM_BR]),
        .oc_i        (syn[3*NUM_BR+1]),
        .force_off_o (force_off),
        .fault_o     (fault_o),
        .standby_o   (standby_o),
        .all_off_o   (all_off_o)
    );

    for (genvar g = 0; g < NUM_BR; g++) begin : g_br
        // Select own pins, or channel A's pins for paired secondaries.
        always_comb begin
            if (g != 0 && paired_q)
                chan_in[g] = '{in1: syn[0], in2: syn[1], pwm: syn[2]};
            else
                chan_in[g] = '{in1: syn[3*g], in2: syn[3*g+1], pwm: syn[3*g+2]};
        end

        hbd_bridge u_bridge (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_i        (chan_in[g]),
            .force_off_i (force_off),
            .cmd_o       (cmd[g]),
            .chg_o       (chg[g])
        );
    end

    assign a_cmd_o = cmd[0];
    assign b_cmd_o = cmd[1];
    assign a_chg_o = chg[0];
    assign b_chg_o = chg[1];

    AST_PAIRED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        paired_q |-> (a_cmd_o == b_cmd_o && a_chg_o == b_chg_o)); // R7
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(paired_q)); // R8
    AST_OVERRIDE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        all_off_o |-> (a_cmd_o == 2'b00 && b_cmd_o == 2'b00)); // R6

endmodule

// File: tb/test_hbd_dual_bridge_ctrl.sv
module test_hbd_dual_bridge_ctrl;

    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pair_mode_i = 1'b0;
    logic a1 = 0, a2 = 0, ap = 0, b1 = 0, b2 = 0, bp = 0, ot = 0, oc = 0;
    logic [1:0] a_cmd_o, b_cmd_o;
    logic a_chg_o, b_chg_o, all_off_o, standby_o, fault_o;

    always #2 clk = ~clk;   // 250 MHz

    hbd_dual_bridge_ctrl i_hbd_dual_bridge_ctrl (
        .clk(clk), .rst_n(rst_n), .pair_mode_i(pair_mode_i),
        .a_in1_i(a1), .a_in2_i(a2), .a_pwm_i(ap),
        .b_in1_i(b1), .b_in2_i(b2), .b_pwm_i(bp),
        .over_temp_i(ot), .over_curr_i(oc),
        .a_cmd_o(a_cmd_o), .b_cmd_o(b_cmd_o),
        .a_chg_o(a_chg_o), .b_chg_o(b_chg_o),
        .all_off_o(all_off_o), .standby_o(standby_o), .fault_o(fault_o));

    typedef struct {
        int         due;
        logic [1:0] ca, cb;
        logic       xa, xb, ao, sb, ft;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t last;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    logic fault_m = 0, paired_m = 0;
    logic [1:0] prev_a = 0, prev_b = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] model_cmd(logic i1, logic i2, logic p);
        if (i1 & i2) return 2'b01;
        if (!i1 & !i2) return 2'b00;
        if (!p) return 2'b01;
        return i1 ? 2'b10 : 2'b11;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (a_cmd_o !== e.ca || b_cmd_o !== e.cb || a_chg_o !== e.xa ||
            b_chg_o !== e.xb || all_off_o !== e.ao || standby_o !== e.sb ||
            fault_o !== e.ft) begin
            failures++;
            $display("FAIL %s cyc=%0d act ca=%b cb=%b xa=%b xb=%b ao=%b sb=%b ft=%b exp ca=%b cb=%b xa=%b xb=%b ao=%b sb=%b ft=%b",
                e.req, cyc, a_cmd_o, b_cmd_o, a_chg_o, b_chg_o, all_off_o, standby_o, fault_o,
                e.ca, e.cb, e.xa, e.xb, e.ao, e.sb, e.ft);
        end
    endtask

    // Monitor: pop expected items when due and compare with the outputs.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) compare(q.pop_front());
    end

    // Driver: apply one input pattern and queue its expected results.
    task automatic step(input logic va1, va2, vap, vb1, vb2, vbp, vot, voc,
                        input string req);
        exp_t e;
        logic alow, off, eb1, eb2, ebp;
        a1 = va1; a2 = va2; ap = vap; b1 = vb1; b2 = vb2; bp = vbp;
        ot = vot; oc = voc;
        alow    = !(va1 | va2 | vap | vb1 | vb2 | vbp);
        fault_m = vot | voc | (fault_m & !alow);
        off     = fault_m | alow;
        eb1 = paired_m ? va1 : vb1;
        eb2 = paired_m ? va2 : vb2;
        ebp = paired_m ? vap : vbp;
        // R12: one edge early the previous steady result still shows.
        e = last; e.due = cyc + LAT - 1; e.xa = 0; e.xb = 0;
        e.req = {"R12 ", req}; q.push_back(e);
        e.due = cyc + LAT;
        e.ca  = off ? 2'b00 : model_cmd(va1, va2, vap);
        e.cb  = off ? 2'b00 : model_cmd(eb1, eb2, ebp);
        e.xa  = ({va1, va2} != prev_a);
        e.xb  = ({eb1, eb2} != prev_b);
        e.ao  = off; e.sb = alow; e.ft = fault_m; e.req = req;
        q.push_back(e);
        e.due = cyc + LAT + 1; e.xa = 0; e.xb = 0;
        e.req = {"R11 ", req}; q.push_back(e);
        last = e;
        prev_a = {va1, va2};
        prev_b = {eb1, eb2};
        repeat (LAT + 3) @(negedge clk);
    endtask

    task automatic do_reset(input logic pm);
        exp_t e;
        @(negedge clk);
        rst_n = 0; pair_mode_i = pm;
        {a1, a2, ap, b1, b2, bp, ot, oc} = '0;
        repeat (3) @(negedge clk);
        e = '{due: 0, ca: 2'b00, cb: 2'b00, xa: 0, xb: 0, ao: 1, sb: 1, ft: 0,
              req: "R1 reset state"};
        compare(e);
        rst_n = 1;
        fault_m = 0; paired_m = pm; prev_a = 0; prev_b = 0;
        repeat (4) @(negedge clk);
        e.req = "R6 standby after reset";
        compare(e);
        last = e;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        step(0,0,1, 0,0,0, 0,0, "R2 off with pwm high");
        step(1,0,1, 0,1,1, 0,0, "R3 A forward B reverse");
        step(0,1,1, 1,0,1, 0,0, "R3 A reverse B forward");
        step(0,1,0, 1,0,0, 0,0, "R5 pwm low brakes, R11 no pulse");
        step(1,1,1, 1,1,0, 0,0, "R4 both high brake");
        step(0,0,0, 0,0,0, 0,0, "R6 all low standby");
        step(0,0,0, 0,0,1, 0,0, "R6 one pin cancels standby");
        pair_mode_i = 1'b1;
        step(1,0,1, 0,1,1, 0,0, "R8 pair pin ignored in run");
        step(1,0,1, 0,1,1, 1,0, "R9 over-temp shutdown");
        step(1,0,1, 0,1,1, 0,0, "R10 latched after flag drop");
        step(0,0,1, 0,0,0, 0,0, "R10 partial low keeps latch");
        step(0,0,0, 0,0,0, 0,0, "R10 all low clears");
        step(1,0,1, 0,1,1, 0,0, "R10 drive after clear");
        step(0,1,1, 1,1,1, 0,1, "R9 over-current shutdown");
        step(0,0,0, 0,0,0, 0,1, "R9 flag dominates all low");
        step(0,0,0, 0,0,0, 0,0, "R10 clear after over-current");
        do_reset(1'b1);
        step(1,0,1, 0,1,1, 0,0, "R7 paired forward");
        step(0,1,1, 1,1,0, 0,0, "R7 paired reverse");
        step(1,1,0, 0,0,0, 0,0, "R7 paired brake");
        pair_mode_i = 1'b0;
        step(1,0,1, 0,1,1, 0,0, "R8 pairing kept after pin drop");
        while (q.size() > 0) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule